// File: doc/BRIEF.md
# Half-Integer Clock Divider with Quadrature Phases

This block takes one input clock and produces a divided clock at one of eight selectable ratios, including the half-integer ratios 1.5 and 2.5. Alongside it, four outputs run at one quarter of the input rate and are spaced 90 degrees apart. A lock flag tells downstream logic when the outputs can be trusted. Every output transition is launched by a flop clocked on an edge of the input clock, so no phase error builds up over time, whatever the ratio.

The ratio is counted in input half-cycles. The divided clock is the XOR of two toggle flops. One toggles on rising input edges and the other on falling input edges, so a half-integer period of 3 or 5 half-cycles comes out with no glitch. Integer ratios have exactly 50% duty. For half-integer ratios, 50% would need an edge in the middle of an input half-cycle, so the high time is one half-cycle longer than the low time. That is the closest duty the input edges allow.

After reset, and after any change of the ratio code, every output is forced low for one cycle. The divider and the phase ring then restart together on the same rising edge. The ratio code is a plain control input, sampled on rising edges of the input clock.

Top module: `halfdiv_clkgen`

## Requirements
- R1: The code on ratio_sel gives the divided period N in input half-cycles: 0→3, 1→4, 2→5, 3→6, 4→8, 5→10, 6→16, 7→32, so the ratios are 1.5, 2, 2.5, 3, 4, 5, 8 and 16.
- R2: clk_div is high for ceil(N/2) and low for floor(N/2) input half-cycles, which is exact 50% duty for every integer ratio.
- R3: Every clk_div edge falls on an input clock edge, and successive periods are identical.
- R4: After reset release, the first rising input edge only captures ratio_sel. clk_div and ph0 first rise on the second rising edge, which is 4 ns after the first at 250 MHz.
- R5: A rising input edge that samples a ratio_sel different from the held code forces clk_div, all four phase outputs and locked low. clk_div rises at the next rising edge with the new ratio.
- R6: ratio_sel is sampled only on rising input edges, so a pulse on it that is gone before the next rising edge has no effect.
- R7: The phase outputs each have a period of 4 input cycles and are high for 2 of them. ph90, ph180 and ph270 lag ph0 by 1, 2 and 3 input cycles, and exactly two of the four are high once locked.
- R8: locked rises N input cycles after the first clk_div rise (two full output periods), together with a clk_div rising edge. It stays high until reset or a code change.
- R9: Asserting rst_n low forces every output low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 3 | Divide ratio code (see R1) |
| clk_div | output | 1 | Divided clock |
| ph0 | output | 1 | Quarter-rate clock, 0 degrees |
| ph90 | output | 1 | Quarter-rate clock, 90 degrees |
| ph180 | output | 1 | Quarter-rate clock, 180 degrees |
| ph270 | output | 1 | Quarter-rate clock, 270 degrees |
| locked | output | 1 | Outputs stable |

## Verification
The bench times every clk_div edge for all eight codes. A wrong slot count or wrap would show up as the wrong period, and odd ratios are the case a design that rises only on the rising input edge gets wrong: it produces uneven periods. Two changes of ratio_sel on consecutive edges, and a code pulse that clears before a rising edge, show whether a design restarts too seldom or too often. A mid-run reset shows whether the outputs clear asynchronously. The lock instant and the four-cycle phase pattern are checked exactly, so a lock counter that is off by one, or a ring that starts with one phase mid-pulse, is reported.

// File: rtl/halfdiv_pkg.sv
package halfdiv_pkg;
  localparam int SEL_W = 3;
  localparam int CNT_W = 6;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // divided period counted in input half-cycles
  function automatic cnt_t half_count(input sel_t code);
    case (code)
      3'd0:    return cnt_t'(3);
      3'd1:    return cnt_t'(4);
      3'd2:    return cnt_t'(5);
      3'd3:    return cnt_t'(6);
      3'd4:    return cnt_t'(8);
      3'd5:    return cnt_t'(10);
      3'd6:    return cnt_t'(16);
      default: return cnt_t'(32);
    endcase
  endfunction
endpackage

// File: rtl/hd_negtog.sv
module hd_negtog (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl,
  output logic lvl
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)   lvl <= 1'b0;
    else if (tgl) lvl <= ~lvl;
  end
endmodule

// File: rtl/hd_phase_ring.sv
module hd_phase_ring #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  output logic [STAGES-1:0] ph
);
  localparam int HALF = STAGES / 2;

  logic [STAGES-1:0] ph_n;

  // twisted ring: stage 0 takes the inverse of the middle stage
  assign ph_n[0] = ~ph[HALF-1];
  for (genvar k = 1; k < STAGES; k++) begin : g_tap
    assign ph_n[k] = ph[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ph <= '0;
    else if (clr) ph <= '0;
    else          ph <= ph_n;
  end
endmodule

// File: rtl/hd_seq.sv
module hd_seq
  import halfdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sel_t sel,
  input  logic b_lvl,
  output logic a_lvl,
  output logic neg_tgl,
  output logic restart,
  output logic locked
);
  logic armed, started;
  sel_t sel_q;
  cnt_t pos, lcnt, nhalf, hhigh, pos_n, slot_n, lcnt_inc;

  function automatic cnt_t wrap(input cnt_t v, input cnt_t lim);
    return (v >= lim) ? v - lim : v;
  endfunction

  function automatic logic edge_hit(input cnt_t s, input cnt_t hi);
    return (s == '0) || (s == hi);
  endfunction

  always_comb begin
    restart  = !armed || (sel != sel_q);
    nhalf    = half_count(sel_q);
    hhigh    = (nhalf + cnt_t'(1)) >> 1;
    pos_n    = started ? wrap(pos + cnt_t'(2), nhalf) : '0;
    slot_n   = wrap(pos_n + cnt_t'(1), nhalf);
    lcnt_inc = lcnt + cnt_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      started <= 1'b0;
      sel_q   <= '0;
      pos     <= '0;
      lcnt    <= '0;
      a_lvl   <= 1'b0;
      neg_tgl <= 1'b0;
      locked  <= 1'b0;
    end else if (restart) begin
      armed   <= 1'b1;
      sel_q   <= sel;
      started <= 1'b0;
      pos     <= '0;
      lcnt    <= '0;
      a_lvl   <= b_lvl;      // XOR output goes low
      neg_tgl <= 1'b0;
      locked  <= 1'b0;
    end else begin
      started <= 1'b1;
      pos     <= pos_n;
      if (edge_hit(pos_n, hhigh)) a_lvl <= ~a_lvl;
      neg_tgl <= edge_hit(slot_n, hhigh);
      if (started && !locked) begin
        lcnt <= lcnt_inc;
        if (lcnt_inc == nhalf) locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/halfdiv_clkgen.sv
module halfdiv_clkgen
  import halfdiv_pkg::*;
#(
  parameter int PH_STAGES = 4
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             clk_div,
  output logic             ph0,
  output logic             ph90,
  output logic             ph180,
  output logic             ph270,
  output logic             locked
);
  logic a_lvl, b_lvl, neg_tgl, restart;
  logic [PH_STAGES-1:0] ph;

  hd_seq u_seq (
    .clk     (clk_in),
    .rst_n   (rst_n),
    .sel     (ratio_sel),
    .b_lvl   (b_lvl),
    .a_lvl   (a_lvl),
    .neg_tgl (neg_tgl),
    .restart (restart),
    .locked  (locked)
  );

  hd_negtog u_neg (
    .clk   (clk_in),
    .rst_n (rst_n),
    .tgl   (neg_tgl),
    .lvl   (b_lvl)
  );

  hd_phase_ring #(.STAGES(PH_STAGES)) u_ring (
    .clk   (clk_in),
    .rst_n (rst_n),
    .clr   (restart),
    .ph    (ph)
  );

  assign clk_div = a_lvl ^ b_lvl;
  assign ph0     = ph[0];
  assign ph90    = ph[1];
  assign ph180   = ph[2];
  assign ph270   = ph[3];
endmodule

// File: rtl/halfdiv_clkgen_chk.sv
module halfdiv_clkgen_chk (
  input logic       clk_in,
  input logic       rst_n,
  input logic [2:0] ratio_sel,
  input logic       clk_div,
  input logic       ph0,
  input logic       ph90,
  input logic       ph180,
  input logic       ph270,
  input logic       locked
);
  logic [3:0] phv;
  assign phv = {ph270, ph180, ph90, ph0};

  AST_RESTART_QUIET: assert property (@(posedge clk_in) disable iff (!rst_n)
    (ratio_sel != $past(ratio_sel)) |=> (!clk_div && !locked && phv == 4'b0000)); // R5

  AST_PHASE_PAIR: assert property (@(posedge clk_in) disable iff (!rst_n)
    locked |-> ($countones(phv) == 2)); // R7

  AST_PHASE_LAG: assert property (@(posedge clk_in) disable iff (!rst_n)
    (locked && $past(locked)) |-> (ph90 == $past(ph0))); // R7

  AST_LOCK_HOLD: assert property (@(posedge clk_in) disable iff (!rst_n)
    (locked && $stable(ratio_sel)) |=> locked); // R8

  AST_LOCK_ON_RISE: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(locked) |-> clk_div); // R8
endmodule

bind halfdiv_clkgen halfdiv_clkgen_chk u_chk (
  .clk_in    (clk_in),
  .rst_n     (rst_n),
  .ratio_sel (ratio_sel),
  .clk_div   (clk_div),
  .ph0       (ph0),
  .ph90      (ph90),
  .ph180     (ph180),
  .ph270     (ph270),
  .locked    (locked)
);

// File: tb/sim_halfdiv_clkgen.sv
`timescale 1ps/1ps
module sim_halfdiv_clkgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ratio_sel = 3'd0;
  logic       clk_div, ph0, ph90, ph180, ph270, locked;

  int     errors = 0;
  int     checks = 0;
  int     cyc = 0;
  longint t_lock = 0;

  halfdiv_clkgen u0 (
    .clk_in(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .clk_div(clk_div),
    .ph0(ph0), .ph90(ph90), .ph180(ph180), .ph270(ph270), .locked(locked)
  );

  always #2000 clk = ~clk;   // 250 MHz

  always @(posedge locked) t_lock = $time;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int exp_half(input int code);
    case (code)
      0: return 3;  1: return 4;  2: return 5;  3: return 6;
      4: return 8;  5: return 10; 6: return 16; default: return 32;
    endcase
  endfunction

  // phase vector {ph270,ph180,ph90,ph0} after rising edge m (m=1 is the start edge)
  function automatic logic [3:0] ph_exp(input int m);
    case ((m - 2) % 4)
      0: return 4'b0011;
      1: return 4'b0110;
      2: return 4'b1100;
      default: return 4'b1001;
    endcase
  endfunction

  function automatic logic [3:0] phv();
    return {ph270, ph180, ph90, ph0};
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // the restart-causing event (release or code change) is already applied
  task automatic measure(input int code, input string first_req);
    int n;
    longint tr, t1, t2, t3, t4;
    n = exp_half(code);
    t_lock = 0;
    @(posedge clk); tr = $time;
    #1000;
    chk("R5", "quiet after restart edge", {clk_div, locked, phv()}, 0);
    @(posedge clk_div); t1 = $time;
    chk(first_req, "first rise delay ps", t1 - tr, 4000);
    @(negedge clk_div); t2 = $time;
    chk("R2", "high time ps", t2 - t1, 2000 * ((n + 1) / 2));
    chk("R3", "fall on input edge", t2 % 2000, 0);
    @(posedge clk_div); t3 = $time;
    chk("R2", "low time ps", t3 - t2, 2000 * (n / 2));
    chk("R1", "period ps", t3 - t1, 2000 * n);
    @(posedge clk_div); t4 = $time;
    chk("R3", "second period ps", t4 - t3, 2000 * n);
    #1000;
    chk("R8", "locked high", locked, 1);
    chk("R8", "lock delay ps", t_lock - t1, 4000 * n);
    for (int i = 0; i < 4; i++) begin
      chk("R7", "phase pattern", phv(), ph_exp(n + 1 + i));
      #4000;
    end
  endtask

  initial begin
    int cur;
    void'($urandom(32'd20240611));
    #3000;
    chk("R9", "reset state", {clk_div, locked, phv()}, 0);
    @(posedge clk); #1000; rst_n = 1'b1;
    measure(0, "R4");
    cur = 0;
    // every code in order (R1 table)
    for (int c = 1; c < 8; c++) begin
      @(posedge clk); #1000; ratio_sel = 3'(c);
      measure(c, "R5");
      cur = c;
    end
    // R6: code pulse that clears before a rising edge
    @(posedge clk); #500; ratio_sel = 3'd2; #1000; ratio_sel = 3'(cur);
    begin
      longint ta, tb;
      @(posedge clk_div); ta = $time;
      @(posedge clk_div); tb = $time;
      chk("R6", "period after ignored pulse", tb - ta, 2000 * exp_half(cur));
      #1000;
      chk("R6", "locked kept", locked, 1);
    end
    // R5: two changes on consecutive edges
    @(posedge clk); #1000; ratio_sel = 3'd4;
    @(posedge clk); #1000;
    chk("R5", "quiet between changes", {clk_div, locked, phv()}, 0);
    ratio_sel = 3'd0;
    measure(0, "R5");
    cur = 0;
    // R9: reset mid-run is immediate
    @(posedge clk); #1000; rst_n = 1'b0;
    #500;
    chk("R9", "async reset clears outputs", {clk_div, locked, phv()}, 0);
    @(posedge clk); #1000; ratio_sel = 3'd2; rst_n = 1'b1;
    measure(2, "R4");
    cur = 2;
    // random codes
    for (int i = 0; i < 8; i++) begin
      int c;
      c = int'($urandom % 8);
      if (c == cur) c = (c + 1) % 8;
      @(posedge clk); #1000; ratio_sel = 3'(c);
      measure(c, "R5");
      cur = c;
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule